// File: doc/BRIEF.md
# Word-to-Longword Bus Matching Packer

This block sits behind the write side of an 18-bit port whose data lands in a 36-bit FIFO. It gathers two accepted word writes, each made of two 9-bit bytes, into one 36-bit entry and pushes that entry in the same cycle as the second write. A static endian input picks which half of the 36-bit port bus carries the word. A swap code picks one of four byte orderings. Together they let a producer of any byte order fill the FIFO so that every entry reads back in one fixed order.

Each active byte of an accepted word write is checked for parity, with the parity sense chosen by an input. A write carrying the mailbox size code does not go to the packer. It loads a separate 36-bit mail register, and a half-built entry stays pending through it.

Top module: `bus_pack_top`

## Requirements
- R1: A word write is accepted on a rising clock edge only when `port_cs`, `port_wr` and `port_en` are all 1, `fifo_full` is 0 and `port_size` is not 2'b11. An unaccepted write leaves the pairing state unchanged and produces no push.
- R2: With `port_big`=1 the word is taken from `port_data[35:18]`. With `port_big`=0 it is taken from `port_data[17:0]`. The other half of the bus has no effect on the entry.
- R3: The first accepted word of a pair produces no push. The second accepted word raises `push_valid` combinationally in its own cycle, for that one cycle only.
- R4: Name the entry bytes A (`push_data[35:27]`), B (`[26:18]`), C (`[17:9]`) and D (`[8:0]`). With `port_big`=1 the transfer order that yields A,B,C,D is as follows. Swap code 2'b00 sends A,B then C,D. Code 2'b01 sends D,C then B,A. Code 2'b10 sends C,D then A,B. Code 2'b11 sends B,A then D,C. Each word's first-named byte is its upper byte. With `port_big`=0 the two words of each of these orders arrive in the opposite sequence.
- R5: The endian and swap inputs are captured on the first word of a pair. Their values during the second word have no effect on lane choice or byte order.
- R6: A write with `port_size`=2'b11 and `port_cs`, `port_wr`, `port_en` all 1 loads all 36 bits of `port_data` into `mail_q` on that edge, whatever the value of `fifo_full`. It neither pushes nor disturbs a pending first word.
- R7: `parity_err` is 1 only during an accepted word write whose two active bytes include one with the wrong parity. `port_odd`=1 requires an odd count of ones in each 9-bit byte, and `port_odd`=0 requires an even count.
- R8: A synchronous reset (`rst`=1) clears the pending first word and `mail_q`.
- R9: `push_valid` is never 1 while `fifo_full` is 1. A second word refused for a full FIFO keeps the first word pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| port_cs | input | 1 | Chip select, active high |
| port_wr | input | 1 | Direction, 1 = write |
| port_en | input | 1 | Transfer enable |
| port_size | input | 2 | Size code, 2'b11 = mailbox |
| port_big | input | 1 | 1 = big-endian lane (upper half) |
| port_swap | input | 2 | Byte swap mode |
| port_odd | input | 1 | Parity sense, 1 = odd |
| port_data | input | 36 | Port data bus |
| fifo_full | input | 1 | FIFO full flag |
| push_valid | output | 1 | One-cycle push strobe |
| push_data | output | 36 | Packed entry |
| parity_err | output | 1 | Parity error on the active bytes |
| mail_q | output | 36 | Mail register contents |

## Verification
The second word of a pair can raise `push_valid` and `parity_err` in the same cycle. It can also meet a full FIFO in the cycle it would complete an entry. The bench sweeps every endian, swap and parity-sense combination. In half of the pairs it flips the configuration inputs on the completing word, and it judges the pushed entry against a byte permutation computed by index arithmetic. Separate cases hold a pair open across a refused write, a full-flag stall and a mailbox write, and check that the later completion still carries the original first word.

// File: rtl/bm_pkg.sv
package bm_pkg;
    parameter int BYTE_W  = 9;
    parameter int WORD_W  = 2 * BYTE_W;
    parameter int ENTRY_W = 2 * WORD_W;
    parameter int NBYTES  = ENTRY_W / BYTE_W;

    localparam logic [1:0] SIZE_MAIL = 2'b11;

    typedef enum logic [1:0] {
        SW_NONE  = 2'b00,
        SW_REV   = 2'b01,
        SW_HALF  = 2'b10,
        SW_INNER = 2'b11
    } swap_e;

    typedef struct packed {
        logic  big;
        swap_e swap;
    } cfg_t;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    function automatic logic byte_bad(input byte_t b, input logic odd_sense);
        return (^b) != odd_sense;
    endfunction

    function automatic entry_t reorder(input entry_t raw, input swap_e mode);
        byte_t a, b, c, d;
        {a, b, c, d} = raw;
        case (mode)
            SW_REV:   return {d, c, b, a};
            SW_HALF:  return {c, d, a, b};
            SW_INNER: return {b, a, d, c};
            default:  return raw;
        endcase
    endfunction
endpackage

// File: rtl/bm_lane_sel.sv
module bm_lane_sel
    import bm_pkg::*;
(
    input  logic   [ENTRY_W-1:0] bus,
    input  logic                 use_upper,
    input  logic                 odd_sense,
    input  logic                 active,
    output logic   [WORD_W-1:0]  word,
    output logic                 perr
);
    localparam int NB = WORD_W / BYTE_W;

    logic [NB-1:0] bad;

    always_comb begin
        if (use_upper) word = bus[ENTRY_W-1:WORD_W];
        else           word = bus[WORD_W-1:0];
    end

    for (genvar g = 0; g < NB; g++) begin : g_chk
        assign bad[g] = byte_bad(word[g*BYTE_W +: BYTE_W], odd_sense);
    end

    assign perr = active & (|bad);
endmodule

// File: rtl/bm_pair_acc.sv
module bm_pair_acc
    import bm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_word,
    input  logic [WORD_W-1:0]   word,
    input  cfg_t                cfg_now,
    output cfg_t                cfg_eff,
    output logic                pending,
    output logic                push_valid,
    output logic [ENTRY_W-1:0]  push_data
);
    logic [WORD_W-1:0] first_q;
    cfg_t              cfg_q;
    entry_t            raw;

    assign cfg_eff    = pending ? cfg_q : cfg_now;
    assign push_valid = wr_word & pending;

    always_comb begin
        if (cfg_q.big) raw = {first_q, word};
        else           raw = {word, first_q};
        push_data = reorder(raw, cfg_q.swap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            first_q <= '0;
            cfg_q   <= '{big: 1'b0, swap: SW_NONE};
        end else if (wr_word) begin
            if (!pending) begin
                first_q <= word;
                cfg_q   <= cfg_now;
                pending <= 1'b1;
            end else begin
                pending <= 1'b0;
            end
        end
    end

    AST_FIRST_OPENS: assert property (@(posedge clk) disable iff (rst)
        (wr_word && !pending) |=> pending); // R3
    AST_PUSH_CLOSES: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> !pending); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_word |=> ($stable(pending) && $stable(first_q))); // R1
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        pending |=> $stable(cfg_q)); // R5
endmodule

// File: rtl/bm_mailbox.sv
module bm_mailbox
    import bm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ENTRY_W-1:0] din,
    output logic [ENTRY_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end

    AST_MAIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din))); // R6
    AST_MAIL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R6
endmodule

// File: rtl/bus_pack_top.sv
module bus_pack_top
    import bm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                port_cs,
    input  logic                port_wr,
    input  logic                port_en,
    input  logic [1:0]          port_size,
    input  logic                port_big,
    input  logic [1:0]          port_swap,
    input  logic                port_odd,
    input  logic [ENTRY_W-1:0]  port_data,
    input  logic                fifo_full,
    output logic                push_valid,
    output logic [ENTRY_W-1:0]  push_data,
    output logic                parity_err,
    output logic [ENTRY_W-1:0]  mail_q
);
    logic        strobe, is_mail, wr_word, wr_mail, pending;
    cfg_t        cfg_now, cfg_eff;
    word_t       word;

    assign strobe  = port_cs & port_wr & port_en;
    assign is_mail = (port_size == SIZE_MAIL);
    assign wr_word = strobe & ~is_mail & ~fifo_full;
    assign wr_mail = strobe & is_mail;
    assign cfg_now = '{big: port_big, swap: swap_e'(port_swap)};

    bm_lane_sel u_lane (
        .bus       (port_data),
        .use_upper (cfg_eff.big),
        .odd_sense (port_odd),
        .active    (wr_word),
        .word      (word),
        .perr      (parity_err)
    );

    bm_pair_acc u_acc (
        .clk        (clk),
        .rst        (rst),
        .wr_word    (wr_word),
        .word       (word),
        .cfg_now    (cfg_now),
        .cfg_eff    (cfg_eff),
        .pending    (pending),
        .push_valid (push_valid),
        .push_data  (push_data)
    );

    bm_mailbox u_mail (
        .clk  (clk),
        .rst  (rst),
        .load (wr_mail),
        .din  (port_data),
        .q    (mail_q)
    );

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !push_valid); // R9
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> !push_valid); // R3
    AST_PERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!port_en || fifo_full) |-> !parity_err); // R7
    AST_MAIL_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (port_size == SIZE_MAIL) |-> !push_valid); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!pending && mail_q == '0)); // R8
endmodule

// File: tb/bus_pack_top_tb_top.sv
module bus_pack_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cs, wr, en, big, odd, full;
    logic [1:0]  sz, sw;
    logic [35:0] data;
    logic        push_valid, parity_err;
    logic [35:0] push_data, mail_q;

    int ncmp = 0;
    int nbad = 0;
    bit done = 0;

    localparam logic [17:0] GARB = 18'h2A5C3;

    always #4 clk = ~clk;

    bus_pack_top dut_i (
        .clk(clk), .rst(rst), .port_cs(cs), .port_wr(wr), .port_en(en),
        .port_size(sz), .port_big(big), .port_swap(sw), .port_odd(odd),
        .port_data(data), .fifo_full(full), .push_valid(push_valid),
        .push_data(push_data), .parity_err(parity_err), .mail_q(mail_q)
    );

    function automatic logic [8:0] mkbyte(input logic [7:0] pl, input logic o);
        return {o ^ (^pl), pl};
    endfunction

    function automatic logic [35:0] lane(input logic b, input logic [17:0] w);
        return b ? {w, GARB} : {GARB, w};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic w, input logic e, input logic [1:0] s,
                         input logic b, input logic [1:0] swp, input logic o,
                         input logic [35:0] d, input logic f);
        @(negedge clk);
        cs = c; wr = w; en = e; sz = s; big = b; sw = swp; odd = o; data = d; full = f;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 2'b00, 1'b1, 36'h0, 1'b0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
            finish_run();
        end
    end

    initial begin
        logic [8:0]  e [4];
        logic [8:0]  r [4];
        logic [17:0] w1, w2;
        logic [35:0] exp;
        int m;

        rst = 1'b1;
        cs = 0; wr = 0; en = 0; sz = 2'b01; big = 1; sw = 0; odd = 1; data = '0; full = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R8 reset push_valid", {35'b0, push_valid}, 36'h0);
        chk("R8 reset mail_q", mail_q, 36'h0);
        chk("R7 reset parity_err", {35'b0, parity_err}, 36'h0);

        // Sweep endian x swap x parity sense x pattern (R2 R3 R4 R5 R7)
        for (int b = 0; b < 2; b++)
        for (int s = 0; s < 4; s++)
        for (int o = 0; o < 2; o++)
        for (int p = 0; p < 2; p++) begin
            m = (s == 1) ? 3 : (s == 2) ? 2 : (s == 3) ? 1 : 0;
            for (int k = 0; k < 4; k++)
                e[k] = mkbyte(8'(b * 37 + s * 11 + o * 5 + p * 71 + k * 29 + 3), o[0]);
            for (int j = 0; j < 4; j++) r[j] = e[j ^ m];
            if (b == 1) begin w1 = {r[0], r[1]}; w2 = {r[2], r[3]}; end
            else        begin w1 = {r[2], r[3]}; w2 = {r[0], r[1]}; end
            exp = {e[0], e[1], e[2], e[3]};
            drive(1, 1, 1, 2'b01, b[0], s[1:0], o[0], lane(b[0], w1), 0);
            chk("R3 first word no push", {35'b0, push_valid}, 36'h0);
            chk("R7 clean parity first", {35'b0, parity_err}, 36'h0);
            if (p == 1)
                drive(1, 1, 1, 2'b10, ~b[0], s[1:0] ^ 2'b11, o[0], lane(b[0], w2), 0);
            else
                drive(1, 1, 1, 2'b00, b[0], s[1:0], o[0], lane(b[0], w2), 0);
            chk("R3 second word push", {35'b0, push_valid}, 36'h1);
            chk(p == 1 ? "R5 config changed mid-pair" : "R4 R2 entry order",
                push_data, exp);
            chk("R7 clean parity second", {35'b0, parity_err}, 36'h0);
        end
        idle();
        chk("R3 strobe one cycle", {35'b0, push_valid}, 36'h0);

        // R1: refused writes leave no pending word
        e[0] = mkbyte(8'h11, 1); e[1] = mkbyte(8'h22, 1);
        e[2] = mkbyte(8'h33, 1); e[3] = mkbyte(8'h44, 1);
        exp = {e[0], e[1], e[2], e[3]};
        drive(1, 1, 0, 2'b01, 1, 0, 1, lane(1, {e[2], e[3]}), 0);
        drive(0, 1, 1, 2'b01, 1, 0, 1, lane(1, {e[2], e[3]}), 0);
        drive(1, 0, 1, 2'b01, 1, 0, 1, lane(1, {e[2], e[3]}), 0);
        chk("R1 refused no push", {35'b0, push_valid}, 36'h0);
        drive(1, 1, 1, 2'b01, 1, 0, 1, lane(1, {e[0], e[1]}), 0);
        chk("R1 first accepted after refusals", {35'b0, push_valid}, 36'h0);
        // R9: full stalls completion
        drive(1, 1, 1, 2'b01, 1, 0, 1, lane(1, {e[2], e[3]}), 1);
        chk("R9 no push while full", {35'b0, push_valid}, 36'h0);
        chk("R7 no parity check while full", {35'b0, parity_err}, 36'h0);
        // R6: mailbox write between pair words, while full
        drive(1, 1, 1, 2'b11, 1, 0, 1, 36'h9_8765_4321, 1);
        chk("R6 mail write no push", {35'b0, push_valid}, 36'h0);
        idle();
        chk("R6 mail_q loaded", mail_q, 36'h9_8765_4321);
        drive(1, 1, 1, 2'b01, 1, 0, 1, lane(1, {e[2], e[3]}), 0);
        chk("R9 R6 pending kept push", {35'b0, push_valid}, 36'h1);
        chk("R9 R6 pending kept data", push_data, exp);
        idle();

        // R7 parity error injection: each active byte, both senses, both lanes
        for (int b = 0; b < 2; b++)
        for (int o = 0; o < 2; o++)
        for (int k = 0; k < 2; k++) begin
            w1 = {mkbyte(8'h5A, o[0]), mkbyte(8'hC3, o[0])};
            w1[k * 9 + 8] = ~w1[k * 9 + 8];
            drive(1, 1, 1, 2'b01, b[0], 0, o[0], lane(b[0], w1), 0);
            chk("R7 bad byte flagged", {35'b0, parity_err}, 36'h1);
            drive(1, 1, 1, 2'b01, b[0], 0, o[0],
                  lane(b[0], {mkbyte(8'h0F, o[0]), mkbyte(8'hF0, o[0])}), 0);
            chk("R7 good pair completes clean", {35'b0, parity_err}, 36'h0);
            drive(1, 1, 0, 2'b01, b[0], 0, o[0], lane(b[0], w1), 0);
            chk("R7 bad byte ignored when idle", {35'b0, parity_err}, 36'h0);
        end
        // R2: bad parity on the inactive lane is not seen
        drive(1, 1, 1, 2'b01, 1, 0, 1,
              {mkbyte(8'h12, 1), mkbyte(8'h34, 1), 18'h00000}, 0);
        chk("R2 inactive lane ignored", {35'b0, parity_err}, 36'h0);
        drive(1, 1, 1, 2'b01, 1, 0, 1,
              {mkbyte(8'h56, 1), mkbyte(8'h78, 1), 18'h00000}, 0);
        chk("R2 pushes upper lane", push_data,
            {mkbyte(8'h12, 1), mkbyte(8'h34, 1), mkbyte(8'h56, 1), mkbyte(8'h78, 1)});

        // R8: reset drops a pending first word and the mail register
        drive(1, 1, 1, 2'b01, 1, 0, 1, lane(1, {e[0], e[1]}), 0);
        @(negedge clk); rst = 1'b1; cs = 0; en = 0;
        @(negedge clk); rst = 1'b0; #1;
        chk("R8 mail cleared", mail_q, 36'h0);
        drive(1, 1, 1, 2'b01, 1, 0, 1, lane(1, {e[2], e[3]}), 0);
        chk("R8 pending cleared", {35'b0, push_valid}, 36'h0);
        idle();

        done = 1;
        finish_run();
    end
endmodule